// File: doc/BRIEF.md
# Network-Interface Bypass Steering Datapath

This block sits between a node's network interface and its router, and adds two bypass paths around the router so the node can use the network even while the router is powered down. The first path carries flits from the ring input port to the interface's ejection port. The second path carries flits from the interface's injection port to the ring output port. When a flit arrives on the ring for some other node, it uses both paths back to back. That flit is forwarded around the gated router, so every node stays reachable through the ring.

A mode input chooses between two settings. In router mode, all four node-side ports connect to the router-side ports. In bypass mode, the router side is held quiet and traffic is steered by the destination field of each packet's head flit. The block changes mode only when no packet is open on any port. While a mode change is pending, new packets are refused, so the block drains to a packet boundary. Both outputs toward the ring and the interface pass through a one-entry register slice.

Top module: `ni_bypass_steer`

## Requirements
- R1: After reset, the block is in router mode and neither `ring_out_valid` nor `ej_valid` is asserted.
- R2: In bypass mode, a packet on the ring input goes to `ej_flit` unchanged when its head flit's destination field, bits [FLIT_W-3 -: ID_W], equals NODE_ID. The route chosen at the head (bit FLIT_W-1) holds for every flit up to the tail (bit FLIT_W-2), whatever the later flits' destination bits hold.
- R3: In bypass mode, flits from the injection port leave on `ring_out_flit` unchanged and in order.
- R4: In bypass mode, a ring-input packet whose head is addressed to another node is forwarded unchanged to `ring_out_flit`.
- R5: In bypass mode, when no packet owns the ring output and a forwarded head and an injected head both wait, the forwarded packet wins and injection is held off.
- R6: A packet owns the ring output from its head to its tail. Flits of forwarded and injected packets never interleave on `ring_out_flit`, even when the owner leaves gaps.
- R7: A change of `use_bypass` takes effect only when no packet is open on any port. While a change is pending, no new head is accepted, and the open packets finish on their current paths.
- R8: In router mode, `ring_in` passes to `rtr_rin`, `inj` passes to `rtr_inj`, `rtr_rout` passes to `ring_out`, and `rtr_ej` passes to `ej`, with flits unchanged.
- R9: Each of `ring_out` and `ej` has a one-entry slice. A held output keeps its valid and flit stable while ready is low, and a full slice refuses new input.
- R10: In bypass mode, `rtr_rin_valid` and `rtr_inj_valid` stay low, and `rtr_rout_ready` and `rtr_ej_ready` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_bypass | input | 1 | 1 requests bypass mode, 0 requests router mode |
| ring_in_valid | input | 1 | Flit on ring input |
| ring_in_ready | output | 1 | Ring input flit accepted |
| ring_in_flit | input | FLIT_W | Ring input flit |
| ring_out_valid | output | 1 | Flit on ring output |
| ring_out_ready | input | 1 | Ring output may advance |
| ring_out_flit | output | FLIT_W | Ring output flit |
| inj_valid | input | 1 | Interface injects a flit |
| inj_ready | output | 1 | Injected flit accepted |
| inj_flit | input | FLIT_W | Injected flit |
| ej_valid | output | 1 | Flit for the interface |
| ej_ready | input | 1 | Interface takes the flit |
| ej_flit | output | FLIT_W | Ejected flit |
| rtr_rin_valid | output | 1 | Ring flit toward router |
| rtr_rin_ready | input | 1 | Router accepts ring flit |
| rtr_rin_flit | output | FLIT_W | Ring flit toward router |
| rtr_inj_valid | output | 1 | Injected flit toward router |
| rtr_inj_ready | input | 1 | Router accepts injected flit |
| rtr_inj_flit | output | FLIT_W | Injected flit toward router |
| rtr_rout_valid | input | 1 | Router sends a ring flit |
| rtr_rout_ready | output | 1 | Ring flit from router accepted |
| rtr_rout_flit | input | FLIT_W | Ring flit from router |
| rtr_ej_valid | input | 1 | Router ejects a flit |
| rtr_ej_ready | output | 1 | Ejected flit from router accepted |
| rtr_ej_flit | input | FLIT_W | Ejected flit from router |

## Verification
In router mode, traffic is offered on all four node-side and router-side ports. A tag in every flit shows which source each output flit came from, so the mode selection is checked flit by flit against per-source expected queues.

In bypass mode, the bench first sends multi-flit packets with misleading destination bits in their body flits. It then sends injected and forwarded packets that start in the same cycle, and an injected packet with gaps that a forwarded head arrives during. These patterns separate routing that is locked per packet from routing done per flit, and fixed priority from first-come ownership.

A mode change requested while an injected packet is half sent shows whether the block waits for the tail and refuses new heads in the meantime. A stalled ring output shows whether the slice holds its flit and refuses a second one.

// File: rtl/ni_bypass_pkg.sv
package ni_bypass_pkg;

    typedef enum logic {
        MODE_RTR = 1'b0,
        MODE_BYP = 1'b1
    } path_mode_e;

    // Source indices for the packet-open trackers
    localparam int SRC_RIN   = 0;
    localparam int SRC_INJ   = 1;
    localparam int SRC_RROUT = 2;
    localparam int SRC_REJ   = 3;
    localparam int NUM_SRC   = 4;

endpackage

// File: rtl/bypass_slice.sv
module bypass_slice #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } slice_t;

    slice_t s_q, s_d;

    assign in_ready  = !s_q.valid || out_ready;
    assign out_valid = s_q.valid;
    assign out_data  = s_q.data;

    always_comb begin
        s_d = s_q;
        if (in_ready) begin
            s_d.valid = in_valid;
            if (in_valid) s_d.data = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pkt_tracker.sv
module pkt_tracker #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire,
    input  logic [N-1:0] tail,
    output logic [N-1:0] open_q
);
    logic [N-1:0] open_d;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_comb begin
            open_d[i] = open_q[i];
            if (fire[i]) open_d[i] = !tail[i];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) open_q[i] <= 1'b0;
            else        open_q[i] <= open_d[i];
        end
    end
endmodule

// File: rtl/ni_bypass_steer.sv
module ni_bypass_steer
    import ni_bypass_pkg::*;
#(
    parameter int          FLIT_W  = 32,
    parameter int          ID_W    = 4,
    parameter int unsigned NODE_ID = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_bypass,
    input  logic              ring_in_valid,
    output logic              ring_in_ready,
    input  logic [FLIT_W-1:0] ring_in_flit,
    output logic              ring_out_valid,
    input  logic              ring_out_ready,
    output logic [FLIT_W-1:0] ring_out_flit,
    input  logic              inj_valid,
    output logic              inj_ready,
    input  logic [FLIT_W-1:0] inj_flit,
    output logic              ej_valid,
    input  logic              ej_ready,
    output logic [FLIT_W-1:0] ej_flit,
    output logic              rtr_rin_valid,
    input  logic              rtr_rin_ready,
    output logic [FLIT_W-1:0] rtr_rin_flit,
    output logic              rtr_inj_valid,
    input  logic              rtr_inj_ready,
    output logic [FLIT_W-1:0] rtr_inj_flit,
    input  logic              rtr_rout_valid,
    output logic              rtr_rout_ready,
    input  logic [FLIT_W-1:0] rtr_rout_flit,
    input  logic              rtr_ej_valid,
    output logic              rtr_ej_ready,
    input  logic [FLIT_W-1:0] rtr_ej_flit
);
    localparam int HEAD_BIT = FLIT_W - 1;
    localparam int TAIL_BIT = FLIT_W - 2;
    localparam int DEST_LSB = FLIT_W - 2 - ID_W;
    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    typedef struct packed {
        path_mode_e mode;
        logic       rin_fwd;   // route locked for the open ring-input packet
    } steer_t;

    steer_t st_q, st_d;
    path_mode_e mode_q;
    assign mode_q = st_q.mode;

    logic [NUM_SRC-1:0] open_q, src_fire, src_tail, allow;
    logic pend, in_byp, rin_fwd_now, fwd_grant, inj_grant, fwd_sel;
    logic rout_in_valid, rout_in_ready, ej_in_valid, ej_in_ready;
    logic [FLIT_W-1:0] rout_in_flit, ej_in_flit;

    always_comb begin
        in_byp = (mode_q == MODE_BYP);
        pend   = (in_byp != use_bypass);
        // a pending switch blocks new heads; open packets run to their tail
        for (int s = 0; s < NUM_SRC; s++) allow[s] = !pend || open_q[s];

        rin_fwd_now = open_q[SRC_RIN] ? st_q.rin_fwd
                                      : (ring_in_flit[DEST_LSB +: ID_W] != MY_ID);
        // ownership of the ring output follows the open packet; forward wins ties
        fwd_grant = !open_q[SRC_INJ];
        inj_grant = open_q[SRC_INJ] ||
                    (!(open_q[SRC_RIN] && st_q.rin_fwd) &&
                     !(ring_in_valid && allow[SRC_RIN] && rin_fwd_now));
        fwd_sel   = ring_in_valid && allow[SRC_RIN] && rin_fwd_now && fwd_grant;

        rtr_rin_flit = ring_in_flit;
        rtr_inj_flit = inj_flit;
        if (in_byp) begin
            rtr_rin_valid  = 1'b0;
            rtr_inj_valid  = 1'b0;
            rtr_rout_ready = 1'b0;
            rtr_ej_ready   = 1'b0;
            ring_in_ready  = allow[SRC_RIN] &&
                             (rin_fwd_now ? (fwd_grant && rout_in_ready) : ej_in_ready);
            inj_ready      = allow[SRC_INJ] && inj_grant && rout_in_ready;
            rout_in_valid  = fwd_sel ||
                             (inj_valid && allow[SRC_INJ] && inj_grant);
            rout_in_flit   = fwd_sel ? ring_in_flit : inj_flit;
            ej_in_valid    = ring_in_valid && allow[SRC_RIN] && !rin_fwd_now;
            ej_in_flit     = ring_in_flit;
        end else begin
            rtr_rin_valid  = ring_in_valid && allow[SRC_RIN];
            ring_in_ready  = rtr_rin_ready && allow[SRC_RIN];
            rtr_inj_valid  = inj_valid && allow[SRC_INJ];
            inj_ready      = rtr_inj_ready && allow[SRC_INJ];
            rout_in_valid  = rtr_rout_valid && allow[SRC_RROUT];
            rtr_rout_ready = rout_in_ready && allow[SRC_RROUT];
            rout_in_flit   = rtr_rout_flit;
            ej_in_valid    = rtr_ej_valid && allow[SRC_REJ];
            rtr_ej_ready   = ej_in_ready && allow[SRC_REJ];
            ej_in_flit     = rtr_ej_flit;
        end

        src_fire[SRC_RIN]   = ring_in_valid && ring_in_ready;
        src_fire[SRC_INJ]   = inj_valid && inj_ready;
        src_fire[SRC_RROUT] = rtr_rout_valid && rtr_rout_ready;
        src_fire[SRC_REJ]   = rtr_ej_valid && rtr_ej_ready;
        src_tail[SRC_RIN]   = ring_in_flit[TAIL_BIT];
        src_tail[SRC_INJ]   = inj_flit[TAIL_BIT];
        src_tail[SRC_RROUT] = rtr_rout_flit[TAIL_BIT];
        src_tail[SRC_REJ]   = rtr_ej_flit[TAIL_BIT];

        st_d = st_q;
        if (src_fire[SRC_RIN] && !open_q[SRC_RIN] && ring_in_flit[HEAD_BIT])
            st_d.rin_fwd = rin_fwd_now;
        if (pend && (open_q == '0))
            st_d.mode = use_bypass ? MODE_BYP : MODE_RTR;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: MODE_RTR, rin_fwd: 1'b0};
        else        st_q <= st_d;
    end

    pkt_tracker #(.N(NUM_SRC)) u_track (
        .clk(clk), .rst_n(rst_n), .fire(src_fire), .tail(src_tail), .open_q(open_q)
    );

    bypass_slice #(.W(FLIT_W)) u_rout_slice (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rout_in_valid), .in_ready(rout_in_ready), .in_data(rout_in_flit),
        .out_valid(ring_out_valid), .out_ready(ring_out_ready), .out_data(ring_out_flit)
    );

    bypass_slice #(.W(FLIT_W)) u_ej_slice (
        .clk(clk), .rst_n(rst_n),
        .in_valid(ej_in_valid), .in_ready(ej_in_ready), .in_data(ej_in_flit),
        .out_valid(ej_valid), .out_ready(ej_ready), .out_data(ej_flit)
    );
endmodule

// File: rtl/ni_bypass_steer_chk.sv
module ni_bypass_steer_chk
    import ni_bypass_pkg::*;
#(
    parameter int          FLIT_W  = 32,
    parameter int          ID_W    = 4,
    parameter int unsigned NODE_ID = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring_in_valid,
    input logic              ring_in_ready,
    input logic [FLIT_W-1:0] ring_in_flit,
    input logic              ring_out_valid,
    input logic              ring_out_ready,
    input logic [FLIT_W-1:0] ring_out_flit,
    input logic              inj_ready,
    input logic              ej_valid,
    input logic              ej_ready,
    input logic [FLIT_W-1:0] ej_flit,
    input logic              rtr_rin_valid,
    input logic              rtr_inj_valid,
    input logic              rtr_rout_ready,
    input logic              rtr_ej_ready,
    input path_mode_e        mode_q,
    input logic [3:0]        open_q
);
    localparam int HEAD_BIT = FLIT_W - 1;
    localparam int DEST_LSB = FLIT_W - 2 - ID_W;
    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    logic fwd_head_waiting;
    assign fwd_head_waiting = ring_in_valid && ring_in_flit[HEAD_BIT] &&
                              (ring_in_flit[DEST_LSB +: ID_W] != MY_ID) && !open_q[0];

    assert_rout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ring_out_valid && !ring_out_ready |=> ring_out_valid && $stable(ring_out_flit));

    assert_ej_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ej_valid && !ej_ready |=> ej_valid && $stable(ej_flit));

    assert_mode_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q != 4'b0) |=> $stable(mode_q));

    assert_router_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BYP) |-> !rtr_rin_valid && !rtr_inj_valid &&
                                 !rtr_rout_ready && !rtr_ej_ready);

    assert_ring_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BYP) && !open_q[1] && fwd_head_waiting |-> !inj_ready);

    assert_no_interleave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BYP) && open_q[1] && fwd_head_waiting |-> !ring_in_ready);
endmodule

bind ni_bypass_steer ni_bypass_steer_chk #(
    .FLIT_W(FLIT_W), .ID_W(ID_W), .NODE_ID(NODE_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ring_in_valid(ring_in_valid), .ring_in_ready(ring_in_ready), .ring_in_flit(ring_in_flit),
    .ring_out_valid(ring_out_valid), .ring_out_ready(ring_out_ready), .ring_out_flit(ring_out_flit),
    .inj_ready(inj_ready),
    .ej_valid(ej_valid), .ej_ready(ej_ready), .ej_flit(ej_flit),
    .rtr_rin_valid(rtr_rin_valid), .rtr_inj_valid(rtr_inj_valid),
    .rtr_rout_ready(rtr_rout_ready), .rtr_ej_ready(rtr_ej_ready),
    .mode_q(mode_q), .open_q(open_q)
);

// File: tb/ni_bypass_steer_test.sv
module ni_bypass_steer_test;
    localparam int W = 32;
    localparam logic [3:0] ME = 4'd5;
    localparam logic [3:0] OTHER = 4'd9;
    // expected-queue selectors
    localparam int Q_FWD = 0, Q_INJ = 1, Q_RTR = 2, Q_EJ = 3, Q_RRIN = 4, Q_RINJ = 5;

    logic clk = 0, rst_n = 0, use_bypass = 0;
    logic ring_in_valid = 0, ring_out_ready = 1, inj_valid = 0, ej_ready = 1;
    logic rtr_rin_ready = 1, rtr_inj_ready = 1, rtr_rout_valid = 0, rtr_ej_valid = 0;
    logic [W-1:0] ring_in_flit = '0, inj_flit = '0, rtr_rout_flit = '0, rtr_ej_flit = '0;
    logic ring_in_ready, ring_out_valid, inj_ready, ej_valid;
    logic rtr_rin_valid, rtr_inj_valid, rtr_rout_ready, rtr_ej_ready;
    logic [W-1:0] ring_out_flit, ej_flit, rtr_rin_flit, rtr_inj_flit;

    always #5 clk = ~clk;

    ni_bypass_steer uut (.*);

    int n_tests = 0, n_fail = 0;
    bit done = 0;
    logic [W-1:0] q_fwd[$], q_inj[$], q_rtr[$], q_ej[$], q_rrin[$], q_rinj[$];
    logic [2:0] log_tag [64];
    int log_n = 0;

    function automatic logic [W-1:0] mk(bit h, bit t, logic [3:0] d, logic [2:0] tag, int seq);
        return {h, t, d, seq[22:0], tag};
    endfunction

    task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(int q, logic [W-1:0] f);
        case (q)
            Q_FWD:  q_fwd.push_back(f);
            Q_INJ:  q_inj.push_back(f);
            Q_RTR:  q_rtr.push_back(f);
            Q_EJ:   q_ej.push_back(f);
            Q_RRIN: q_rrin.push_back(f);
            default: q_rinj.push_back(f);
        endcase
    endtask

    // drivers: present at negedge, hold until ready seen, return at a negedge
    task automatic send_rin(logic [W-1:0] f, int q);
        push(q, f);
        ring_in_valid = 1; ring_in_flit = f;
        forever begin
            #4;
            if (ring_in_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        ring_in_valid = 0;
    endtask

    task automatic send_inj(logic [W-1:0] f, int q);
        push(q, f);
        inj_valid = 1; inj_flit = f;
        forever begin
            #4;
            if (inj_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        inj_valid = 0;
    endtask

    task automatic send_rrout(logic [W-1:0] f);
        push(Q_RTR, f);
        rtr_rout_valid = 1; rtr_rout_flit = f;
        forever begin
            #4;
            if (rtr_rout_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        rtr_rout_valid = 0;
    endtask

    task automatic send_rej(logic [W-1:0] f);
        push(Q_EJ, f);
        rtr_ej_valid = 1; rtr_ej_flit = f;
        forever begin
            #4;
            if (rtr_ej_ready) begin @(negedge clk); break; end
            @(negedge clk);
        end
        rtr_ej_valid = 0;
    endtask

    // monitors: sample handshakes just before the rising edge
    initial begin
        logic [W-1:0] e;
        forever begin
            @(negedge clk); #4;
            if (rst_n && ring_out_valid && ring_out_ready) begin
                if (log_n < 64) begin log_tag[log_n] = ring_out_flit[2:0]; log_n++; end
                case (ring_out_flit[2:0])
                    3'd0: begin e = (q_fwd.size() > 0) ? q_fwd.pop_front() : 'x;
                          chk(ring_out_flit === e, "R4 forward", ring_out_flit, e); end
                    3'd1: begin e = (q_inj.size() > 0) ? q_inj.pop_front() : 'x;
                          chk(ring_out_flit === e, "R3 send", ring_out_flit, e); end
                    default: begin e = (q_rtr.size() > 0) ? q_rtr.pop_front() : 'x;
                          chk(ring_out_flit === e, "R8 router ring out", ring_out_flit, e); end
                endcase
            end
            if (rst_n && ej_valid && ej_ready) begin
                e = (q_ej.size() > 0) ? q_ej.pop_front() : 'x;
                chk(ej_flit === e, "R2 eject", ej_flit, e);
            end
            if (rst_n && rtr_rin_valid && rtr_rin_ready) begin
                e = (q_rrin.size() > 0) ? q_rrin.pop_front() : 'x;
                chk(rtr_rin_flit === e, "R8 ring to router", rtr_rin_flit, e);
            end
            if (rst_n && rtr_inj_valid && rtr_inj_ready) begin
                e = (q_rinj.size() > 0) ? q_rinj.pop_front() : 'x;
                chk(rtr_inj_flit === e, "R8 inject to router", rtr_inj_flit, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] f1, f2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #4;
        // R1: outputs idle after reset
        chk(!ring_out_valid, "R1 ring_out_valid", W'(ring_out_valid), 0);
        chk(!ej_valid, "R1 ej_valid", W'(ej_valid), 0);
        @(negedge clk);

        // R8: router mode pass-through, local dest still goes to router (R1 mode)
        send_rin(mk(1, 0, ME, 0, 1), Q_RRIN);
        send_rin(mk(0, 1, ME, 0, 2), Q_RRIN);
        fork
            send_inj(mk(1, 1, OTHER, 1, 3), Q_RINJ);
            begin send_rrout(mk(1, 0, OTHER, 2, 4)); send_rrout(mk(0, 1, OTHER, 2, 5)); end
            send_rej(mk(1, 1, ME, 3, 6));
        join
        repeat (3) @(negedge clk);

        // enter bypass mode
        use_bypass = 1;
        repeat (3) @(negedge clk);
        // R10: router side gets no ready in bypass mode
        rtr_rout_valid = 1; rtr_rout_flit = mk(1, 1, OTHER, 2, 99);
        rtr_ej_valid = 1;   rtr_ej_flit = mk(1, 1, ME, 3, 98);
        #4;
        chk(!rtr_rout_ready, "R10 rtr_rout_ready", W'(rtr_rout_ready), 0);
        chk(!rtr_ej_ready, "R10 rtr_ej_ready", W'(rtr_ej_ready), 0);
        @(negedge clk);
        rtr_rout_valid = 0; rtr_ej_valid = 0;

        // R2: local packet ejected, body dest bits do not change the route
        send_rin(mk(1, 0, ME, 0, 10), Q_EJ);
        send_rin(mk(0, 0, OTHER, 0, 11), Q_EJ);
        send_rin(mk(0, 1, OTHER, 0, 12), Q_EJ);
        // R3: send path
        send_inj(mk(1, 0, OTHER, 1, 13), Q_INJ);
        send_inj(mk(0, 1, ME, 1, 14), Q_INJ);
        // R4: forward path, body dest equal to own id stays forwarded
        send_rin(mk(1, 0, OTHER, 0, 15), Q_FWD);
        send_rin(mk(0, 1, ME, 0, 16), Q_FWD);
        repeat (4) @(negedge clk);

        // R5: simultaneous heads, forwarded packet first
        log_n = 0;
        fork
            begin send_rin(mk(1, 0, OTHER, 0, 20), Q_FWD); send_rin(mk(0, 1, OTHER, 0, 21), Q_FWD); end
            begin send_inj(mk(1, 0, OTHER, 1, 22), Q_INJ); send_inj(mk(0, 1, OTHER, 1, 23), Q_INJ); end
        join
        repeat (4) @(negedge clk);
        chk(log_n == 4, "R5 flit count", W'(log_n), 4);
        chk(log_tag[0] == 0 && log_tag[1] == 0, "R5 forward first", {log_tag[0], log_tag[1]}, 0);
        chk(log_tag[2] == 1 && log_tag[3] == 1, "R5 inject after", {log_tag[2], log_tag[3]}, 'h9);

        // R6: injected packet with gaps keeps ownership
        log_n = 0;
        fork
            begin
                send_inj(mk(1, 0, OTHER, 1, 30), Q_INJ);
                repeat (3) @(negedge clk);
                send_inj(mk(0, 0, OTHER, 1, 31), Q_INJ);
                send_inj(mk(0, 1, OTHER, 1, 32), Q_INJ);
            end
            begin @(negedge clk); send_rin(mk(1, 1, OTHER, 0, 33), Q_FWD); end
        join
        repeat (4) @(negedge clk);
        chk(log_n == 4, "R6 flit count", W'(log_n), 4);
        chk(log_tag[0] == 1 && log_tag[1] == 1 && log_tag[2] == 1, "R6 inject packet whole",
            {log_tag[0], log_tag[1], log_tag[2]}, 'h49);
        chk(log_tag[3] == 0, "R6 forward after tail", W'(log_tag[3]), 0);

        // R9: stalled ring output holds and refuses a second flit
        ring_out_ready = 0;
        f1 = mk(1, 1, OTHER, 1, 40);
        f2 = mk(1, 1, OTHER, 1, 41);
        send_inj(f1, Q_INJ);
        inj_valid = 1; inj_flit = f2;
        #4;
        chk(ring_out_valid, "R9 valid held", W'(ring_out_valid), 1);
        chk(ring_out_flit === f1, "R9 flit held", ring_out_flit, f1);
        chk(!inj_ready, "R9 full slice refuses", W'(inj_ready), 0);
        @(negedge clk); #4;
        chk(ring_out_flit === f1, "R9 flit stable", ring_out_flit, f1);
        @(negedge clk);
        ring_out_ready = 1;
        send_inj(f2, Q_INJ);
        repeat (3) @(negedge clk);

        // R7: switch back waits for the open injected packet; new heads blocked
        send_inj(mk(1, 0, OTHER, 1, 50), Q_INJ);
        use_bypass = 0;
        fork
            send_rin(mk(1, 1, ME, 0, 51), Q_RRIN);
            begin
                #4;
                chk(!ring_in_ready, "R7 new head blocked", W'(ring_in_ready), 0);
                chk(!rtr_rin_valid, "R7 router path not yet", W'(rtr_rin_valid), 0);
                @(negedge clk); @(negedge clk);
                send_inj(mk(0, 1, OTHER, 1, 52), Q_INJ);
            end
        join
        send_inj(mk(1, 1, OTHER, 1, 53), Q_RINJ);

        for (int i = 0; i < 50; i++) begin
            if (q_fwd.size() + q_inj.size() + q_rtr.size() + q_ej.size() +
                q_rrin.size() + q_rinj.size() == 0) break;
            @(negedge clk);
        end
        chk(q_fwd.size() == 0, "R4 drained", W'(q_fwd.size()), 0);
        chk(q_inj.size() == 0, "R3 drained", W'(q_inj.size()), 0);
        chk(q_ej.size() == 0, "R2 drained", W'(q_ej.size()), 0);
        chk(q_rtr.size() + q_rrin.size() + q_rinj.size() == 0, "R8 drained",
            W'(q_rtr.size() + q_rrin.size() + q_rinj.size()), 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule